// File: doc/BRIEF.md
# Link Frame Generator

This block turns a stream of words from a transmit FIFO into framed traffic for a serial link that uses 8B/10B coding. Each frame opens with a start marker whose low three bits carry the present state of the two parallel I/O lines and the direction line. Up to `MAX_WORDS` data words follow, then an optional CRC word, then an end marker. IDLE words fill the time between frames. The encoder, the serializer and the receive path are outside the block. Ordered sets leave the block as small symbolic codes with `tx_k` high. Data and CRC words leave with `tx_k` low.

A frame closes early when the FIFO runs dry or when a word flagged as SYNC goes out. That word is then the last data word of the frame, and the end marker records it. A one-cycle request from software produces a frame that holds no data, only the SYNC marking. The far end throttles the block through a GO/STOP input. While it reads STOP, words stay in the FIFO and no data frame begins. A frame that has already started runs to its end.

Top module: `lfg_framer`

## Requirements
- R1: While reset is held and in the cycle after it, `tx_k` is 1, `tx_word` is the IDLE code 0x3C, and `fifo_rd` is 0.
- R2: A start marker is the code 0x40 | (pio1<<2) | (pio2<<1) | dir, with `tx_k`=1. The line states are those sampled in the cycle the frame is started.
- R3: Data words leave with `tx_k`=0, in FIFO order and each exactly once. A frame holds at most `MAX_WORDS` (512) of them. A longer backlog continues in the following frame.
- R4: A data frame whose FIFO runs empty ends at once. If no SYNC word was sent, its end marker is 0x50.
- R5: A word with the SYNC indication is the last data word of its frame. That frame ends with the marker 0x51.
- R6: When `sync_bit0_mode` is 1, bit 0 of each data word gives the SYNC indication and `fifo_sync` is ignored. When it is 0, `fifo_sync` gives it.
- R7: A one-cycle pulse on `send_sync` produces a frame made of a start marker directly followed by the end marker 0x51, with no data word and no CRC word. This frame is not held back by STOP.
- R8: When `crc_en` is 1 at frame start, a data frame carries one extra word between its last data word and its end marker. That word is the CRC-32 of the frame's data words: polynomial 0x04C11DB7, initial value all ones, most significant bit first, no final inversion. The per-frame overhead is then six words instead of five.
- R9: At least `IDLE_GAP` (3) IDLE words separate an end marker, or the end of reset, from the next start marker. When more data waits, exactly `IDLE_GAP` IDLE words are sent.
- R10: While `remote_go` is 0, no data frame starts and `fifo_rd` stays 0 outside a frame. A frame already under way completes.
- R11: `fifo_rd` is asserted only when `fifo_empty` is 0. The popped word appears on `tx_word` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | WORD_W | Head word of the show-ahead FIFO |
| fifo_sync | input | 1 | SYNC flag stored with the head word |
| fifo_rd | output | 1 | Pops the head word at this clock edge |
| remote_go | input | 1 | Far-end flow state, 1 = GO, 0 = STOP |
| send_sync | input | 1 | Pulse requesting a frame with SYNC and no data |
| pio1 | input | 1 | First parallel I/O line, carried in the start marker |
| pio2 | input | 1 | Second parallel I/O line, carried in the start marker |
| dir | input | 1 | Direction line, carried in the start marker |
| crc_en | input | 1 | Adds a CRC word to data frames |
| sync_bit0_mode | input | 1 | Takes the SYNC indication from data bit 0 |
| tx_word | output | WORD_W | Outgoing word, or the ordered-set code when tx_k is 1 |
| tx_k | output | 1 | 1 = tx_word is an ordered-set code |

## Verification
A preloaded backlog of 1030 unflagged words shows the split at 512 words and the exact three-word gap between back-to-back frames. Dropping GO in the middle of the first frame separates "finish the frame" from "start no new frame". A burst with SYNC flags and CRC enabled shows the early close on a flagged word, the 0x51 marker and the CRC arithmetic. A run in bit-0 mode, with conflicting FIFO flags, shows which source decides SYNC. A sweep over all eight line-state combinations, with CRC off and on, checks every start-marker code and both overhead lengths. A `send_sync` pulse under STOP checks the data-less frame.

// File: rtl/lfg_pkg.sv
package lfg_pkg;

   localparam logic [7:0] CODE_IDLE      = 8'h3C;
   localparam logic [7:0] CODE_SOF_BASE  = 8'h40;
   localparam logic [7:0] CODE_EOF_PLAIN = 8'h50;
   localparam logic [7:0] CODE_EOF_SYNC  = 8'h51;
   localparam logic [31:0] CRC_POLY      = 32'h04C11DB7;

   typedef enum logic [2:0] {
      SEL_IDLE,
      SEL_SOF,
      SEL_DATA,
      SEL_CRC,
      SEL_EOF
   } sel_e;

   typedef enum logic [1:0] {
      ST_GAP,
      ST_DATA,
      ST_CRC,
      ST_EOF
   } st_e;

   function automatic logic [7:0] sof_code(input logic p1, input logic p2, input logic d);
      return CODE_SOF_BASE | {5'b0, p1, p2, d};
   endfunction

endpackage

// File: rtl/lfg_crc.sv
module lfg_crc #(
   parameter int          WORD_W = 32,
   parameter logic [31:0] POLY   = 32'h04C11DB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              upd,
   input  logic [WORD_W-1:0] din,
   output logic [31:0]       crc_q
);

   logic [31:0] crc_nxt;

   // Bit-serial division unrolled over one word, MSB first.
   always_comb begin
      logic [31:0] c;
      logic        fb;
      c = crc_q;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         fb = c[31] ^ din[i];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      crc_nxt = c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_q <= '1;
      else if (init) crc_q <= '1;
      else if (upd)  crc_q <= crc_nxt;
   end

endmodule

// File: rtl/lfg_ctrl.sv
module lfg_ctrl
   import lfg_pkg::*;
#(
   parameter int MAX_WORDS   = 512,
   parameter int IDLE_GAP    = 3,
   parameter int CRC_PRESENT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_empty,
   input  logic data_b0,
   input  logic fifo_sync,
   input  logic remote_go,
   input  logic crc_en,
   input  logic sync_bit0_mode,
   input  logic send_sync,
   output logic fifo_rd,
   output sel_e sel,
   output logic frm_sync,
   output logic crc_init,
   output logic crc_upd
);

   localparam int WCNT_W = $clog2(MAX_WORDS + 1);
   localparam int GAP_W  = $clog2(IDLE_GAP + 1);

   st_e               st, st_n;
   logic [GAP_W-1:0]  gap_cnt, gap_n;
   logic [WCNT_W-1:0] wcnt, wcnt_n;
   logic              fs_n;
   logic              frm_crc, fc_n;
   logic              sync_pend, sync_take;
   logic              word_sync, gap_ok, last_slot, crc_on;

   assign word_sync = sync_bit0_mode ? data_b0 : fifo_sync;
   assign gap_ok    = (gap_cnt == GAP_W'(IDLE_GAP));
   assign last_slot = (wcnt == WCNT_W'(MAX_WORDS - 1));
   assign crc_on    = (CRC_PRESENT != 0) && crc_en;

   always_comb begin
      st_n      = st;
      gap_n     = gap_cnt;
      wcnt_n    = wcnt;
      fs_n      = frm_sync;
      fc_n      = frm_crc;
      sel       = SEL_IDLE;
      fifo_rd   = 1'b0;
      crc_init  = 1'b0;
      crc_upd   = 1'b0;
      sync_take = 1'b0;
      case (st)
         ST_GAP: begin
            if (gap_ok && sync_pend) begin
               // data-less SYNC frame: marker pair only
               sel       = SEL_SOF;
               sync_take = 1'b1;
               fs_n      = 1'b1;
               fc_n      = 1'b0;
               st_n      = ST_EOF;
            end else if (gap_ok && remote_go && !fifo_empty) begin
               sel      = SEL_SOF;
               fs_n     = 1'b0;
               fc_n     = crc_on;
               wcnt_n   = '0;
               crc_init = 1'b1;
               st_n     = ST_DATA;
            end else begin
               sel = SEL_IDLE;
               if (!gap_ok) gap_n = gap_cnt + GAP_W'(1);
            end
         end
         ST_DATA: begin
            if (fifo_empty) begin
               if (frm_crc) begin
                  sel  = SEL_CRC;
                  st_n = ST_EOF;
               end else begin
                  sel   = SEL_EOF;
                  gap_n = '0;
                  st_n  = ST_GAP;
               end
            end else begin
               sel     = SEL_DATA;
               fifo_rd = 1'b1;
               crc_upd = 1'b1;
               wcnt_n  = wcnt + WCNT_W'(1);
               fs_n    = word_sync;
               if (word_sync || last_slot) st_n = frm_crc ? ST_CRC : ST_EOF;
            end
         end
         ST_CRC: begin
            sel  = SEL_CRC;
            st_n = ST_EOF;
         end
         ST_EOF: begin
            sel   = SEL_EOF;
            gap_n = '0;
            st_n  = ST_GAP;
         end
         default: st_n = ST_GAP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_GAP;
         gap_cnt   <= '0;
         wcnt      <= '0;
         frm_sync  <= 1'b0;
         frm_crc   <= 1'b0;
         sync_pend <= 1'b0;
      end else begin
         st        <= st_n;
         gap_cnt   <= gap_n;
         wcnt      <= wcnt_n;
         frm_sync  <= fs_n;
         frm_crc   <= fc_n;
         sync_pend <= send_sync | (sync_pend & ~sync_take);
      end
   end

endmodule

// File: rtl/lfg_outmux.sv
module lfg_outmux
   import lfg_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sel_e              sel,
   input  logic              pio1,
   input  logic              pio2,
   input  logic              dir,
   input  logic              frm_sync,
   input  logic [WORD_W-1:0] data,
   input  logic [31:0]       crc,
   output logic [WORD_W-1:0] tx_word,
   output logic              tx_k
);

   logic [WORD_W-1:0] w_n;
   logic              k_n;

   always_comb begin
      w_n = WORD_W'(CODE_IDLE);
      k_n = 1'b1;
      case (sel)
         SEL_SOF:  w_n = WORD_W'(sof_code(pio1, pio2, dir));
         SEL_DATA: begin w_n = data;          k_n = 1'b0; end
         SEL_CRC:  begin w_n = WORD_W'(crc);  k_n = 1'b0; end
         SEL_EOF:  w_n = frm_sync ? WORD_W'(CODE_EOF_SYNC) : WORD_W'(CODE_EOF_PLAIN);
         default:  w_n = WORD_W'(CODE_IDLE);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_word <= WORD_W'(CODE_IDLE);
         tx_k    <= 1'b1;
      end else begin
         tx_word <= w_n;
         tx_k    <= k_n;
      end
   end

endmodule

// File: rtl/lfg_framer.sv
module lfg_framer
   import lfg_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int MAX_WORDS   = 512,
   parameter int IDLE_GAP    = 3,
   parameter int CRC_PRESENT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] fifo_data,
   input  logic              fifo_sync,
   output logic              fifo_rd,
   input  logic              remote_go,
   input  logic              send_sync,
   input  logic              pio1,
   input  logic              pio2,
   input  logic              dir,
   input  logic              crc_en,
   input  logic              sync_bit0_mode,
   output logic [WORD_W-1:0] tx_word,
   output logic              tx_k
);

   generate
      if (WORD_W < 32) begin : g_bad_width
         $error("lfg_framer: WORD_W must be at least 32");
      end
      if (MAX_WORDS < 1) begin : g_bad_len
         $error("lfg_framer: MAX_WORDS must be at least 1");
      end
      if (IDLE_GAP < 1) begin : g_bad_gap
         $error("lfg_framer: IDLE_GAP must be at least 1");
      end
   endgenerate

   sel_e        sel;
   logic        frm_sync;
   logic        crc_init;
   logic        crc_upd;
   logic [31:0] crc_val;

   lfg_ctrl #(
      .MAX_WORDS  (MAX_WORDS),
      .IDLE_GAP   (IDLE_GAP),
      .CRC_PRESENT(CRC_PRESENT)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .fifo_empty    (fifo_empty),
      .data_b0       (fifo_data[0]),
      .fifo_sync     (fifo_sync),
      .remote_go     (remote_go),
      .crc_en        (crc_en),
      .sync_bit0_mode(sync_bit0_mode),
      .send_sync     (send_sync),
      .fifo_rd       (fifo_rd),
      .sel           (sel),
      .frm_sync      (frm_sync),
      .crc_init      (crc_init),
      .crc_upd       (crc_upd)
   );

   generate
      if (CRC_PRESENT != 0) begin : g_crc
         lfg_crc #(
            .WORD_W(WORD_W),
            .POLY  (CRC_POLY)
         ) u_crc (
            .clk  (clk),
            .rst_n(rst_n),
            .init (crc_init),
            .upd  (crc_upd),
            .din  (fifo_data),
            .crc_q(crc_val)
         );
      end else begin : g_nocrc
         assign crc_val = '0;
      end
   endgenerate

   lfg_outmux #(
      .WORD_W(WORD_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .pio1    (pio1),
      .pio2    (pio2),
      .dir     (dir),
      .frm_sync(frm_sync),
      .data    (fifo_data),
      .crc     (crc_val),
      .tx_word (tx_word),
      .tx_k    (tx_k)
   );

endmodule

// File: rtl/lfg_chk.sv
module lfg_chk
   import lfg_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int MAX_WORDS = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_empty,
   input logic              fifo_rd,
   input logic              remote_go,
   input logic [WORD_W-1:0] tx_word,
   input logic              tx_k
);

   localparam int RUN_W = $clog2(MAX_WORDS + 3);

   logic [RUN_W-1:0] run;
   logic             is_sof, is_eof, is_idle;

   assign is_idle = tx_k && (tx_word == WORD_W'(CODE_IDLE));
   assign is_sof  = tx_k && ((tx_word >> 3) == WORD_W'(CODE_SOF_BASE >> 3));
   assign is_eof  = tx_k && ((tx_word == WORD_W'(CODE_EOF_PLAIN)) ||
                             (tx_word == WORD_W'(CODE_EOF_SYNC)));

   // length of the current run of non-ordered-set words
   always_ff @(posedge clk) begin
      if (!rst_n)         run <= '0;
      else if (tx_k)      run <= '0;
      else if (run != '1) run <= run + RUN_W'(1);
   end

   // R11
   a_r11_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> !fifo_empty);

   // R11
   a_r11_pop_to_data: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> !tx_k);

   // R9
   a_r9_eof_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      is_eof |=> is_idle);

   // R9
   a_r9_sof_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      is_sof |-> $past(is_idle));

   // R10
   a_r10_go_before_data: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_k && $past(is_sof)) |-> $past(remote_go, 2));

   // R3, R8: data words plus at most one CRC word per frame
   a_r3_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
      run <= RUN_W'(MAX_WORDS + 1));

endmodule

bind lfg_framer lfg_chk #(
   .WORD_W   (WORD_W),
   .MAX_WORDS(MAX_WORDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fifo_empty(fifo_empty),
   .fifo_rd   (fifo_rd),
   .remote_go (remote_go),
   .tx_word   (tx_word),
   .tx_k      (tx_k)
);

// File: tb/lfg_framer_tb.sv
module lfg_framer_tb;

   localparam int DEPTH = 2048;
   localparam int GAP   = 3;
   localparam int MAXW  = 512;
   localparam int M_OUT = 0, M_SOF = 1, M_DAT = 2, M_CRC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_empty, fifo_sync, fifo_rd;
   logic [31:0] fifo_data;
   logic        remote_go = 1'b0, send_sync = 1'b0;
   logic        pio1 = 1'b0, pio2 = 1'b0, dir = 1'b0;
   logic        crc_en = 1'b0, sync_bit0_mode = 1'b0;
   logic [31:0] tx_word;
   logic        tx_k;

   always #2 clk = ~clk;   // 250 MHz

   lfg_framer u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .fifo_sync(fifo_sync), .fifo_rd(fifo_rd), .remote_go(remote_go),
      .send_sync(send_sync), .pio1(pio1), .pio2(pio2), .dir(dir), .crc_en(crc_en),
      .sync_bit0_mode(sync_bit0_mode), .tx_word(tx_word), .tx_k(tx_k)
   );

   // show-ahead FIFO model
   logic [31:0] f_data [DEPTH];
   logic        f_flag [DEPTH];
   logic [31:0] e_data [DEPTH];
   logic        e_sync [DEPTH];
   logic        e_end  [DEPTH];
   int wr = 0;
   int rd = 0;

   assign fifo_empty = (rd == wr);
   assign fifo_data  = f_data[rd % DEPTH];
   assign fifo_sync  = f_flag[rd % DEPTH];

   always @(posedge clk) if (fifo_rd && rd != wr) rd <= rd + 1;

   int n_run = 0, n_fail = 0, m_run = 0, m_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic mchk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      m_run++;
      if (!ok) begin
         m_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] w);
      logic [31:0] r;
      r = c;
      for (int i = 31; i >= 0; i--) begin
         if (r[31] ^ w[i]) r = (r << 1) ^ 32'h04C11DB7;
         else              r = r << 1;
      end
      return r;
   endfunction

   // ---------------- stream monitor ----------------
   int mst = M_OUT, gap = 0, cnt = 0, mptr = 0;
   int frames = 0, sync_only = 0, crc_seen = 0, eof_sync = 0;
   int gap_log [256];
   logic [31:0] crcv;
   bit should_end = 0, last_sync = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         mst = M_OUT; gap = 0;
      end else begin
         if (fifo_rd && fifo_empty) mchk(0, "R11 pop while empty", 1, 0);
         if (tx_k) begin
            if (tx_word == 32'h3C) begin
               mchk(mst == M_OUT, "R9 IDLE inside a frame", mst, M_OUT);
               gap++;
            end else if (tx_word[31:3] == 29'h8) begin
               mchk(mst == M_OUT, "R2 start marker inside a frame", mst, M_OUT);
               mchk(gap >= GAP, "R9 gap before start marker", gap, GAP);
               mchk(tx_word[2:0] == {pio1, pio2, dir}, "R2 start marker code", tx_word, {29'h8, pio1, pio2, dir});
               gap_log[frames % 256] = gap;
               mst = M_SOF; cnt = 0; crcv = 32'hFFFF_FFFF; should_end = 0; last_sync = 0;
            end else if (tx_word == 32'h50 || tx_word == 32'h51) begin
               if (mst == M_SOF) begin
                  mchk(tx_word == 32'h51, "R7 data-less frame end marker", tx_word, 32'h51);
                  sync_only++;
               end else if (mst == M_DAT) begin
                  mchk(should_end, "R4 frame ended early", cnt, 0);
                  mchk(!crc_en, "R8 CRC word missing", 0, 1);
                  mchk(tx_word == (last_sync ? 32'h51 : 32'h50), "R5 end marker code", tx_word, last_sync ? 32'h51 : 32'h50);
               end else if (mst == M_CRC) begin
                  mchk(tx_word == (last_sync ? 32'h51 : 32'h50), "R5 end marker code", tx_word, last_sync ? 32'h51 : 32'h50);
               end else begin
                  mchk(0, "R9 end marker outside a frame", tx_word, 32'h3C);
               end
               if (tx_word == 32'h51) eof_sync++;
               frames++; mst = M_OUT; gap = 0;
            end else begin
               mchk(0, "R1 unknown ordered set", tx_word, 32'h3C);
            end
         end else begin
            if (mst == M_DAT && should_end) begin
               mchk(crc_en, "R3 word past frame end", tx_word, 0);
               mchk(tx_word == crcv, "R8 CRC value", tx_word, crcv);
               crc_seen++;
               mst = M_CRC;
            end else if (mst == M_SOF || mst == M_DAT) begin
               mchk(tx_word == e_data[mptr % DEPTH], "R3 data order", tx_word, e_data[mptr % DEPTH]);
               crcv = crc_step(crcv, tx_word);
               cnt++;
               last_sync  = e_sync[mptr % DEPTH];
               should_end = e_sync[mptr % DEPTH] || e_end[mptr % DEPTH] || (cnt == MAXW);
               mptr++;
               mst = M_DAT;
            end else begin
               mchk(0, "R11 data word outside a frame", tx_word, 32'h3C);
            end
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic push(input logic [31:0] d, input logic fl);
      f_data[wr % DEPTH] = d;
      f_flag[wr % DEPTH] = fl;
      e_data[wr % DEPTH] = d;
      e_sync[wr % DEPTH] = sync_bit0_mode ? d[0] : fl;
      e_end[wr % DEPTH]  = 1'b0;
      wr++;
   endtask

   task automatic mark_end();
      e_end[(wr - 1) % DEPTH] = 1'b1;
   endtask

   task automatic drain();
      int k = 0;
      while (k < 4000 && !(rd == wr && mst == M_OUT)) begin
         @(negedge clk);
         k++;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic hold_check(input int n, input string tag);
      bit moved = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (fifo_rd || !tx_k || tx_word != 32'h3C) moved = 1;
      end
      chk(!moved, tag, moved, 0);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      int f0, s0, c0, r0;
      repeat (5) @(negedge clk);
      chk(tx_k == 1'b1, "R1 tx_k in reset", tx_k, 1);
      chk(tx_word == 32'h3C, "R1 IDLE in reset", tx_word, 32'h3C);
      chk(fifo_rd == 1'b0, "R1 no pop in reset", fifo_rd, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_k && tx_word == 32'h3C, "R1 IDLE after reset", tx_word, 32'h3C);

      // empty FIFO with GO: only IDLE
      remote_go = 1'b1;
      hold_check(20, "R4 empty FIFO sends IDLE only");
      remote_go = 1'b0;

      // long backlog, GO dropped mid-frame
      {pio1, pio2, dir} = 3'b101; crc_en = 1'b0; sync_bit0_mode = 1'b0;
      f0 = frames;
      for (int i = 0; i < 1030; i++) push(32'hA000_0000 + i, 1'b0);
      mark_end();
      hold_check(30, "R10 STOP holds data");
      remote_go = 1'b1;
      while (rd == 0) @(negedge clk);
      remote_go = 1'b0;
      repeat (700) @(negedge clk);
      chk(rd == 512, "R10 started frame completes, no new frame", rd, 512);
      chk(frames == f0 + 1, "R3 one full frame under STOP", frames - f0, 1);
      remote_go = 1'b1;
      drain();
      chk(frames == f0 + 3, "R3 backlog split into 512+512+6", frames - f0, 3);
      chk(gap_log[(f0 + 2) % 256] == GAP, "R9 exact gap with data waiting", gap_log[(f0 + 2) % 256], GAP);
      chk(mptr == wr, "R11 every word sent once", mptr, wr);
      remote_go = 1'b0;

      // SYNC flags with CRC
      {pio1, pio2, dir} = 3'b010; crc_en = 1'b1;
      f0 = frames; c0 = crc_seen; s0 = eof_sync;
      for (int i = 0; i < 20; i++) push((i * 32'h0101_0101) ^ 32'h5A5A_0000, (i == 4) || (i == 11));
      mark_end();
      remote_go = 1'b1;
      drain();
      chk(frames == f0 + 3, "R5 SYNC words close frames", frames - f0, 3);
      chk(eof_sync == s0 + 2, "R5 two SYNC end markers", eof_sync - s0, 2);
      chk(crc_seen == c0 + 3, "R8 CRC word in each frame", crc_seen - c0, 3);
      chk(gap_log[(f0 + 1) % 256] == GAP && gap_log[(f0 + 2) % 256] == GAP, "R9 exact gap after SYNC frame",
          gap_log[(f0 + 2) % 256], GAP);
      remote_go = 1'b0;

      // SYNC taken from data bit 0, FIFO flag ignored
      {pio1, pio2, dir} = 3'b111; crc_en = 1'b0; sync_bit0_mode = 1'b1;
      f0 = frames; s0 = eof_sync;
      for (int i = 0; i < 12; i++) push((i == 5) ? 32'h0000_1235 : (i << 4), i == 2);
      mark_end();
      remote_go = 1'b1;
      drain();
      chk(frames == f0 + 2, "R6 bit0 decides SYNC, flag ignored", frames - f0, 2);
      chk(eof_sync == s0 + 1, "R6 one SYNC end marker", eof_sync - s0, 1);
      remote_go = 1'b0;
      sync_bit0_mode = 1'b0;

      // data-less SYNC frame under STOP
      {pio1, pio2, dir} = 3'b000;
      f0 = frames; s0 = sync_only; r0 = rd;
      for (int i = 0; i < 4; i++) push(32'hC0DE_0000 | i, 1'b0);
      mark_end();
      hold_check(30, "R10 STOP holds data again");
      @(negedge clk) send_sync = 1'b1;
      @(negedge clk) send_sync = 1'b0;
      repeat (20) @(negedge clk);
      chk(sync_only == s0 + 1, "R7 data-less SYNC frame sent", sync_only - s0, 1);
      chk(rd == r0, "R7 no word popped by SYNC frame", rd, r0);
      remote_go = 1'b1;
      drain();
      chk(frames == f0 + 2, "R10 data frame after GO returns", frames - f0, 2);
      remote_go = 1'b0;

      // sweep over line states and CRC setting
      for (int p = 0; p < 8; p++) begin
         for (int c = 0; c < 2; c++) begin
            {pio1, pio2, dir} = p[2:0]; crc_en = c[0];
            f0 = frames; c0 = crc_seen;
            for (int i = 0; i < 3; i++) push({8'hB0, 5'd0, p[2:0], 7'd0, c[0], 8'd0} + i, 1'b0);
            mark_end();
            remote_go = 1'b1;
            drain();
            remote_go = 1'b0;
            chk(frames == f0 + 1, "R2 sweep frame per line state", frames - f0, 1);
            chk(crc_seen == c0 + c, "R8 sweep CRC presence", crc_seen - c0, c);
         end
      end

      chk(mptr == wr, "R11 all pushed words delivered", mptr, wr);
      chk(m_fail == 0, "R3 stream monitor clean", m_fail, 0);
      $display("[TB] %0d tests run, %0d failed", n_run + m_run, n_fail + m_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog R1 run did not finish actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run + m_run + 1, n_fail + m_fail + 1);
      $finish;
   end

endmodule